// File: doc/BRIEF.md
# Two-Level Class Queue Rate Scheduler

This block decides, once per clock, which class queue of a subscriber may send its head packet. Each class queue owns two token buckets, a guaranteed (minimum) bucket and a peak (maximum) bucket, together with an excess weight and a priority. The subscriber node above the queues owns a ceiling bucket that gates every queue. All buckets refill by a programmed increment on each credit tick and are capped at a programmed burst size. A grant deducts the head packet length from the buckets it draws on.

Packets sent while the queue's guaranteed bucket is positive are green. Packets sent from the excess share are yellow. Green traffic always wins over yellow, and within either colour the higher priority wins. Ties are settled by rotating pointers: plain round-robin for green, and weighted round-robin for yellow. When low-priority traffic has drained the subscriber ceiling, a top-priority queue can still send green within its own guarantee. Per-queue counters record green sends, yellow sends and red drops. A red drop is an arrival reported against a queue that the external buffer flags as full.

Top module: `hqos_sched`

## Requirements
- R1: After reset there is no grant, every bucket is empty (level 0) and all green, yellow and red counters read zero.
- R2: A bucket is eligible only while its level is above zero. On a tick the level becomes min(level + increment, burst). A grant that uses the bucket then subtracts the head length in the same cycle. With no tick, no grant is issued.
- R3: A queue whose peak bucket is at or below zero is never granted.
- R4: While the subscriber ceiling bucket is at or below zero, no queue below the top priority (4) is granted.
- R5: While the ceiling is empty, a backlogged priority-4 queue with a positive guaranteed bucket and a positive peak bucket is still granted as green. Its length is deducted from all three buckets, and the ceiling saturates at -2^(TW-1).
- R6: The block first considers queues that are backlogged and eligible with a positive guaranteed bucket (green). Only when none exist does it consider queues with an empty guaranteed bucket and a nonzero weight (yellow). Inside a colour, the highest priority value (0 lowest, 4 highest) wins.
- R7: Among green candidates of the same priority, the first queue at or after the green pointer wins. The pointer then moves to the granted queue + 1, modulo NQ.
- R8: Among yellow candidates of the same priority, the first queue at or after the excess pointer wins. The pointer stays on a queue for weight consecutive yellow grants before moving to the next queue. A queue with weight 0 is never granted yellow.
- R9: A green grant deducts from the queue's guaranteed bucket, peak bucket and the ceiling, and increments that queue's green counter. A yellow grant deducts from the peak bucket and the ceiling only, and increments the yellow counter. Counters wrap at 2^CW.
- R10: An arrival strobe whose target queue has its full flag set increments that queue's red counter by one. Arrivals to a queue that is not full change no counter.
- R11: Configuration address = {index, field[2:0]}. For index 0..NQ-1, field 0 sets the guaranteed increment, 1 the guaranteed burst, 2 the peak increment, 3 the peak burst, 4 the weight (clamped to 2^WW-1) and 5 the priority (clamped to 4). Index NQ selects the ceiling: field 2 sets its increment and field 3 its burst. All other writes are ignored. A write takes effect on the decision of the following cycle.
- R12: At most one grant is issued per clock. The grant appears on the outputs one clock after the cycle in which the decision was made, and it always names a queue that was backlogged in that decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Credit refill strobe |
| qBacklog | input | NQ | Queue has a head packet |
| qHeadLen | input | NQ*LW | Head packet length per queue |
| arrValid | input | 1 | Arrival strobe |
| arrQueue | input | log2(NQ) | Arrival target queue |
| qFull | input | NQ | Queue is at its depth limit |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | log2(NQ+1)+3 | Configuration address {index, field} |
| cfgData | input | TW-1 | Configuration value |
| grantValid | output | 1 | A grant is issued |
| grantQueue | output | log2(NQ) | Granted queue |
| grantGreen | output | 1 | 1 green, 0 yellow |
| greenCnt | output | NQ*CW | Green send counters |
| yellowCnt | output | NQ*CW | Yellow send counters |
| redCnt | output | NQ*CW | Red drop counters |

## Verification
The hardest state to reach from the ports is the subscriber ceiling being empty while lower-priority queues are still backlogged and hold peak credit. That is where the protection path alone decides. The stimulus gets there by programming a ceiling increment of zero and leaving every queue backlogged until grants drain the ceiling below zero. It then keeps ticking the queue buckets for a long window, so that only the priority-4 queue's guarantee can release traffic. Weighted excess rotation is reached by giving two queues a zero guarantee and unequal weights, so that every grant between them is yellow.

// File: rtl/hqos_pkg.sv
package hqos_pkg;
  localparam int QMAX = 8;

  typedef struct packed {
    logic            fire;
    logic            green;
    logic [QMAX-1:0] queue;
  } hqos_strobe_t;
endpackage

// File: rtl/hqos_bucket.sv
module hqos_bucket #(
  parameter int TW = 20,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic [TW-2:0] inc,
  input  logic [TW-2:0] burst,
  input  logic          deduct,
  input  logic [LW-1:0] len,
  output logic          ok
);
  localparam int XW = TW + 2;

  logic signed [XW-1:0] level;
  logic signed [XW-1:0] sum;
  logic signed [XW-1:0] floorV;

  assign floorV = -(XW'(1) << (TW - 1));

  always_comb begin
    sum = level;
    if (tick) begin
      sum = sum + $signed({3'b000, inc});
      if (sum > $signed({3'b000, burst})) sum = $signed({3'b000, burst});
    end
    if (deduct) begin
      sum = sum - $signed({{(XW-LW){1'b0}}, len});
      if (sum < floorV) sum = floorV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) level <= '0;
    else if (tick || deduct) level <= sum;
  end

  assign ok = (level > 0);
endmodule

// File: rtl/hqos_datapath.sv
module hqos_datapath
  import hqos_pkg::*;
#(
  parameter int NQ = 8,
  parameter int TW = 20,
  parameter int LW = 14,
  parameter int CW = 16,
  parameter int WW = 4,
  parameter int PW = 3,
  parameter int PLEVELS = 5,
  localparam int QW = $clog2(NQ),
  localparam int IXW = $clog2(NQ + 1),
  localparam int AW = IXW + 3,
  localparam int DW = TW - 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tick,
  input  logic [NQ*LW-1:0] qHeadLen,
  input  logic           arrValid,
  input  logic [QW-1:0]  arrQueue,
  input  logic [NQ-1:0]  qFull,
  input  logic           cfgWe,
  input  logic [AW-1:0]  cfgAddr,
  input  logic [DW-1:0]  cfgData,
  input  hqos_strobe_t   strobe,
  output logic [NQ-1:0]  minOk,
  output logic [NQ-1:0]  maxOk,
  output logic           nodeOk,
  output logic [NQ*PW-1:0] prioFlat,
  output logic [NQ*WW-1:0] weightFlat,
  output logic [NQ*CW-1:0] greenCnt,
  output logic [NQ*CW-1:0] yellowCnt,
  output logic [NQ*CW-1:0] redCnt
);
  localparam int WMAX = (1 << WW) - 1;
  localparam int PMAX = PLEVELS - 1;

  logic [DW-1:0] minInc [NQ];
  logic [DW-1:0] minBurst [NQ];
  logic [DW-1:0] maxInc [NQ];
  logic [DW-1:0] maxBurst [NQ];
  logic [WW-1:0] weight [NQ];
  logic [PW-1:0] prio [NQ];
  logic [DW-1:0] nodeInc, nodeBurst;
  logic [CW-1:0] gCnt [NQ];
  logic [CW-1:0] yCnt [NQ];
  logic [CW-1:0] rCnt [NQ];

  logic [IXW-1:0] cfgIdx;
  logic [2:0]     cfgFld;
  logic [LW-1:0]  selLen;
  logic [NQ-1:0]  hitQ;

  assign cfgIdx = cfgAddr[AW-1:3];
  assign cfgFld = cfgAddr[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NQ; q++) begin
        minInc[q] <= '0; minBurst[q] <= '0;
        maxInc[q] <= '0; maxBurst[q] <= '0;
        weight[q] <= '0; prio[q] <= '0;
      end
      nodeInc <= '0;
      nodeBurst <= '0;
    end else if (cfgWe) begin
      for (int q = 0; q < NQ; q++) begin
        if (cfgIdx == IXW'(q)) begin
          case (cfgFld)
            3'd0: minInc[q] <= cfgData;
            3'd1: minBurst[q] <= cfgData;
            3'd2: maxInc[q] <= cfgData;
            3'd3: maxBurst[q] <= cfgData;
            3'd4: weight[q] <= (cfgData > DW'(WMAX)) ? WW'(WMAX) : cfgData[WW-1:0];
            3'd5: prio[q] <= (cfgData > DW'(PMAX)) ? PW'(PMAX) : cfgData[PW-1:0];
            default: ;
          endcase
        end
      end
      if (cfgIdx == IXW'(NQ)) begin
        if (cfgFld == 3'd2) nodeInc <= cfgData;
        if (cfgFld == 3'd3) nodeBurst <= cfgData;
      end
    end
  end

  always_comb begin
    selLen = '0;
    hitQ = '0;
    for (int q = 0; q < NQ; q++) begin
      if (strobe.fire && strobe.queue == QMAX'(q)) begin
        hitQ[q] = 1'b1;
        selLen = qHeadLen[q*LW +: LW];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : gQueue
      hqos_bucket #(.TW(TW), .LW(LW)) uMin (
        .clk(clk), .rstN(rstN), .tick(tick),
        .inc(minInc[g]), .burst(minBurst[g]),
        .deduct(hitQ[g] && strobe.green),
        .len(qHeadLen[g*LW +: LW]), .ok(minOk[g])
      );
      hqos_bucket #(.TW(TW), .LW(LW)) uMax (
        .clk(clk), .rstN(rstN), .tick(tick),
        .inc(maxInc[g]), .burst(maxBurst[g]),
        .deduct(hitQ[g]),
        .len(qHeadLen[g*LW +: LW]), .ok(maxOk[g])
      );
      assign prioFlat[g*PW +: PW]   = prio[g];
      assign weightFlat[g*WW +: WW] = weight[g];
      assign greenCnt[g*CW +: CW]   = gCnt[g];
      assign yellowCnt[g*CW +: CW]  = yCnt[g];
      assign redCnt[g*CW +: CW]     = rCnt[g];
    end
  endgenerate

  hqos_bucket #(.TW(TW), .LW(LW)) uNode (
    .clk(clk), .rstN(rstN), .tick(tick),
    .inc(nodeInc), .burst(nodeBurst),
    .deduct(strobe.fire), .len(selLen), .ok(nodeOk)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NQ; q++) begin
        gCnt[q] <= '0; yCnt[q] <= '0; rCnt[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (hitQ[q] && strobe.green) gCnt[q] <= gCnt[q] + 1'b1;
        if (hitQ[q] && !strobe.green) yCnt[q] <= yCnt[q] + 1'b1;
        if (arrValid && qFull[arrQueue] && arrQueue == QW'(q)) rCnt[q] <= rCnt[q] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hqos_ctrl.sv
module hqos_ctrl
  import hqos_pkg::*;
#(
  parameter int NQ = 8,
  parameter int WW = 4,
  parameter int PW = 3,
  parameter int PLEVELS = 5,
  localparam int QW = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NQ-1:0]    qBacklog,
  input  logic [NQ-1:0]    minOk,
  input  logic [NQ-1:0]    maxOk,
  input  logic             nodeOk,
  input  logic [NQ*PW-1:0] prioFlat,
  input  logic [NQ*WW-1:0] weightFlat,
  output hqos_strobe_t     strobe,
  output logic             grantValid,
  output logic [QW-1:0]    grantQueue,
  output logic             grantGreen
);
  localparam logic [PW-1:0] PTOP = PW'(PLEVELS - 1);

  logic [PW-1:0] prio [NQ];
  logic [WW-1:0] weight [NQ];
  logic [NQ-1:0] elig, greenC, excC, greenSet, excSet;
  logic [PW-1:0] topG, topX;
  logic [QW-1:0] greenPtr, excPtr;
  logic [WW-1:0] excRun;
  logic [WW:0]   runCnt;
  int            pickIdx;

  function automatic int pickFrom(input logic [NQ-1:0] m, input int ptr);
    int r;
    r = 0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (m[(ptr + i) % NQ]) r = (ptr + i) % NQ;
    end
    return r;
  endfunction

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      prio[q] = prioFlat[q*PW +: PW];
      weight[q] = weightFlat[q*WW +: WW];
      elig[q] = qBacklog[q] && maxOk[q] && (nodeOk || (prio[q] == PTOP && minOk[q]));
      greenC[q] = elig[q] && minOk[q];
      excC[q] = elig[q] && !minOk[q] && (weight[q] != '0);
    end
    topG = '0;
    topX = '0;
    for (int q = 0; q < NQ; q++) begin
      if (greenC[q] && prio[q] > topG) topG = prio[q];
      if (excC[q] && prio[q] > topX) topX = prio[q];
    end
    for (int q = 0; q < NQ; q++) begin
      greenSet[q] = greenC[q] && prio[q] == topG;
      excSet[q] = excC[q] && prio[q] == topX;
    end
    strobe = '0;
    pickIdx = 0;
    if (|greenC) begin
      pickIdx = pickFrom(greenSet, int'(greenPtr));
      strobe.fire = 1'b1;
      strobe.green = 1'b1;
    end else if (|excC) begin
      pickIdx = pickFrom(excSet, int'(excPtr));
      strobe.fire = 1'b1;
    end
    strobe.queue = QMAX'(pickIdx);
    runCnt = (QW'(pickIdx) == excPtr) ? ({1'b0, excRun} + 1'b1) : (WW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      greenPtr <= '0;
      excPtr <= '0;
      excRun <= '0;
      grantValid <= 1'b0;
      grantQueue <= '0;
      grantGreen <= 1'b0;
    end else begin
      grantValid <= strobe.fire;
      grantQueue <= strobe.fire ? QW'(pickIdx) : '0;
      grantGreen <= strobe.fire && strobe.green;
      if (strobe.fire && strobe.green) begin
        greenPtr <= QW'((pickIdx + 1) % NQ);
      end else if (strobe.fire) begin
        if (runCnt >= {1'b0, weight[pickIdx]}) begin
          excPtr <= QW'((pickIdx + 1) % NQ);
          excRun <= '0;
        end else begin
          excPtr <= QW'(pickIdx);
          excRun <= runCnt[WW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/hqos_sched.sv
module hqos_sched
  import hqos_pkg::*;
#(
  parameter int NQ = 8,
  parameter int TW = 20,
  parameter int LW = 14,
  parameter int CW = 16,
  parameter int WW = 4,
  parameter int PW = 3,
  parameter int PLEVELS = 5,
  localparam int QW = $clog2(NQ),
  localparam int AW = $clog2(NQ + 1) + 3,
  localparam int DW = TW - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [NQ-1:0]    qBacklog,
  input  logic [NQ*LW-1:0] qHeadLen,
  input  logic             arrValid,
  input  logic [QW-1:0]    arrQueue,
  input  logic [NQ-1:0]    qFull,
  input  logic             cfgWe,
  input  logic [AW-1:0]    cfgAddr,
  input  logic [DW-1:0]    cfgData,
  output logic             grantValid,
  output logic [QW-1:0]    grantQueue,
  output logic             grantGreen,
  output logic [NQ*CW-1:0] greenCnt,
  output logic [NQ*CW-1:0] yellowCnt,
  output logic [NQ*CW-1:0] redCnt
);
  hqos_strobe_t    strobe;
  logic [NQ-1:0]   minOk, maxOk;
  logic            nodeOk;
  logic [NQ*PW-1:0] prioFlat;
  logic [NQ*WW-1:0] weightFlat;

  hqos_ctrl #(.NQ(NQ), .WW(WW), .PW(PW), .PLEVELS(PLEVELS)) uCtrl (
    .clk(clk), .rstN(rstN), .qBacklog(qBacklog),
    .minOk(minOk), .maxOk(maxOk), .nodeOk(nodeOk),
    .prioFlat(prioFlat), .weightFlat(weightFlat),
    .strobe(strobe), .grantValid(grantValid),
    .grantQueue(grantQueue), .grantGreen(grantGreen)
  );

  hqos_datapath #(.NQ(NQ), .TW(TW), .LW(LW), .CW(CW), .WW(WW), .PW(PW),
                  .PLEVELS(PLEVELS)) uData (
    .clk(clk), .rstN(rstN), .tick(tick), .qHeadLen(qHeadLen),
    .arrValid(arrValid), .arrQueue(arrQueue), .qFull(qFull),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobe(strobe), .minOk(minOk), .maxOk(maxOk), .nodeOk(nodeOk),
    .prioFlat(prioFlat), .weightFlat(weightFlat),
    .greenCnt(greenCnt), .yellowCnt(yellowCnt), .redCnt(redCnt)
  );
endmodule

// File: rtl/hqos_sched_chk.sv
module hqos_sched_chk
  import hqos_pkg::*;
#(
  parameter int NQ = 8,
  parameter int CW = 16,
  parameter int PW = 3,
  parameter int PLEVELS = 5,
  localparam int QW = $clog2(NQ)
) (
  input logic             clk,
  input logic             rstN,
  input logic [NQ-1:0]    qBacklog,
  input logic [NQ-1:0]    qFull,
  input logic             arrValid,
  input logic [QW-1:0]    arrQueue,
  input logic             grantValid,
  input logic [QW-1:0]    grantQueue,
  input logic             grantGreen,
  input logic [NQ-1:0]    minOk,
  input logic [NQ-1:0]    maxOk,
  input logic             nodeOk,
  input logic [NQ*PW-1:0] prioFlat,
  input hqos_strobe_t     strobe,
  input logic [NQ*CW-1:0] redCnt
);
  logic [NQ-1:0] backlogD;
  logic [QW-1:0] arrQD;
  logic [CW-1:0] redNow, redPrevQ;
  logic          minSel, maxSel;
  logic [PW-1:0] prioSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      backlogD <= '0;
      arrQD <= '0;
    end else begin
      backlogD <= qBacklog;
      arrQD <= arrQueue;
    end
  end

  always_comb begin
    minSel = 1'b0;
    maxSel = 1'b0;
    prioSel = '0;
    for (int q = 0; q < NQ; q++) begin
      if (strobe.queue == QMAX'(q)) begin
        minSel = minOk[q];
        maxSel = maxOk[q];
        prioSel = prioFlat[q*PW +: PW];
      end
    end
    redNow = redCnt[arrQueue*CW +: CW];
    redPrevQ = redCnt[arrQD*CW +: CW];
  end

  AST_GRANT_BACKLOG: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> backlogD[grantQueue]); // R12

  AST_GRANT_REGISTERED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> grantValid && QMAX'(grantQueue) == $past(strobe.queue)
                    && grantGreen == $past(strobe.green)); // R12

  AST_PEAK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> maxSel); // R3

  AST_CEILING_GATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && !nodeOk |-> strobe.green && prioSel == PW'(PLEVELS - 1)); // R4

  AST_PROTECT_GREEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && strobe.green |-> minSel); // R5

  AST_GREEN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && !strobe.green |-> (qBacklog & maxOk & minOk) == '0); // R6

  AST_RED_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    arrValid && qFull[arrQueue] |=> redPrevQ == CW'($past(redNow) + 1'b1)); // R10
endmodule

bind hqos_sched hqos_sched_chk #(.NQ(NQ), .CW(CW), .PW(PW), .PLEVELS(PLEVELS)) u_chk (
  .clk(clk), .rstN(rstN), .qBacklog(qBacklog), .qFull(qFull),
  .arrValid(arrValid), .arrQueue(arrQueue), .grantValid(grantValid),
  .grantQueue(grantQueue), .grantGreen(grantGreen), .minOk(minOk),
  .maxOk(maxOk), .nodeOk(nodeOk), .prioFlat(prioFlat), .strobe(strobe),
  .redCnt(redCnt)
);

// File: tb/hqos_sched_bench.sv
module hqos_sched_bench;
  localparam int NQ = 8, TW = 20, LW = 14, CW = 16, WW = 4, PW = 3;
  localparam int QW = 3, AW = 7, DW = 19;
  localparam int FLOORV = -(1 << (TW - 1));

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic [NQ-1:0] bl = '0, full = '0;
  logic [NQ*LW-1:0] hlFlat;
  logic arrV = 1'b0, cfgWe = 1'b0;
  logic [QW-1:0] arrQ = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic [DW-1:0] cfgData = '0;
  logic gV, gG;
  logic [QW-1:0] gQ;
  logic [NQ*CW-1:0] gCntF, yCntF, rCntF;
  int hl [NQ];

  always #10 clk = ~clk;

  always_comb for (int q = 0; q < NQ; q++) hlFlat[q*LW +: LW] = LW'(hl[q]);

  hqos_sched u_hqos_sched (
    .clk(clk), .rstN(rstN), .tick(tick), .qBacklog(bl), .qHeadLen(hlFlat),
    .arrValid(arrV), .arrQueue(arrQ), .qFull(full), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .grantValid(gV), .grantQueue(gQ),
    .grantGreen(gG), .greenCnt(gCntF), .yellowCnt(yCntF), .redCnt(rCntF)
  );

  int nChk = 0, nFail = 0;
  string curReq = "R1";

  // behavioural reference state
  int mMinInc[NQ], mMinBur[NQ], mMaxInc[NQ], mMaxBur[NQ], mW[NQ], mP[NQ];
  int mMinLv[NQ], mMaxLv[NQ], mGc[NQ], mYc[NQ], mRc[NQ];
  int mNodeInc, mNodeBur, mNodeLv, gPtr, xPtr, xRun;
  int eV, eQ, eG;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refill(int lv, int inc, int bur, bit t, bit d, int len);
    int v = lv;
    if (t) begin v = v + inc; if (v > bur) v = bur; end
    if (d) begin v = v - len; if (v < FLOORV) v = FLOORV; end
    return v;
  endfunction

  task automatic modelStep();
    int pick = -1, topG = -1, topX = -1, cnt, idx, fld;
    bit grn = 0;
    bit el[NQ], gc[NQ], xc[NQ];
    for (int q = 0; q < NQ; q++) begin
      el[q] = bl[q] && mMaxLv[q] > 0 && (mNodeLv > 0 || (mP[q] == 4 && mMinLv[q] > 0));
      gc[q] = el[q] && mMinLv[q] > 0;
      xc[q] = el[q] && mMinLv[q] <= 0 && mW[q] > 0;
      if (gc[q] && mP[q] > topG) topG = mP[q];
      if (xc[q] && mP[q] > topX) topX = mP[q];
    end
    if (topG >= 0) begin
      grn = 1;
      for (int i = 0; i < NQ; i++) begin
        idx = (gPtr + i) % NQ;
        if (pick < 0 && gc[idx] && mP[idx] == topG) pick = idx;
      end
    end else if (topX >= 0) begin
      for (int i = 0; i < NQ; i++) begin
        idx = (xPtr + i) % NQ;
        if (pick < 0 && xc[idx] && mP[idx] == topX) pick = idx;
      end
    end
    for (int q = 0; q < NQ; q++) begin
      mMinLv[q] = refill(mMinLv[q], mMinInc[q], mMinBur[q], tick, pick == q && grn, hl[q]);
      mMaxLv[q] = refill(mMaxLv[q], mMaxInc[q], mMaxBur[q], tick, pick == q, hl[q]);
    end
    mNodeLv = refill(mNodeLv, mNodeInc, mNodeBur, tick, pick >= 0, pick >= 0 ? hl[pick] : 0);
    if (pick >= 0) begin
      if (grn) begin
        gPtr = (pick + 1) % NQ;
        mGc[pick] = (mGc[pick] + 1) % 65536;
      end else begin
        cnt = (pick == xPtr) ? xRun + 1 : 1;
        if (cnt >= mW[pick]) begin xPtr = (pick + 1) % NQ; xRun = 0; end
        else begin xPtr = pick; xRun = cnt; end
        mYc[pick] = (mYc[pick] + 1) % 65536;
      end
    end
    if (arrV && full[arrQ]) mRc[arrQ] = (mRc[arrQ] + 1) % 65536;
    if (cfgWe) begin
      idx = int'(cfgAddr) >> 3;
      fld = int'(cfgAddr) & 7;
      if (idx < NQ) begin
        case (fld)
          0: mMinInc[idx] = int'(cfgData);
          1: mMinBur[idx] = int'(cfgData);
          2: mMaxInc[idx] = int'(cfgData);
          3: mMaxBur[idx] = int'(cfgData);
          4: mW[idx] = (int'(cfgData) > 15) ? 15 : int'(cfgData);
          5: mP[idx] = (int'(cfgData) > 4) ? 4 : int'(cfgData);
          default: ;
        endcase
      end else if (idx == NQ) begin
        if (fld == 2) mNodeInc = int'(cfgData);
        if (fld == 3) mNodeBur = int'(cfgData);
      end
    end
    eV = (pick >= 0);
    eQ = (pick >= 0) ? pick : 0;
    eG = grn;
  endtask

  task automatic compareAll();
    bit ok;
    int a = 0, e = 0;
    ok = (int'(gV) == eV);
    if (!ok) begin a = gV; e = eV; end
    if (ok && eV) begin
      if (int'(gQ) != eQ) begin ok = 0; a = gQ; e = eQ; end
      else if (int'(gG) != eG) begin ok = 0; a = gG; e = eG; end
    end
    for (int q = 0; q < NQ; q++) begin
      if (ok && int'(gCntF[q*CW +: CW]) != mGc[q]) begin ok = 0; a = gCntF[q*CW +: CW]; e = mGc[q]; end
      if (ok && int'(yCntF[q*CW +: CW]) != mYc[q]) begin ok = 0; a = yCntF[q*CW +: CW]; e = mYc[q]; end
      if (ok && int'(rCntF[q*CW +: CW]) != mRc[q]) begin ok = 0; a = rCntF[q*CW +: CW]; e = mRc[q]; end
    end
    chk(ok, curReq, a, e);
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic cfgWrite(input int idx, input int fld, input int val);
    cfgWe = 1'b1;
    cfgAddr = AW'((idx << 3) | fld);
    cfgData = DW'(val);
    cycle();
    cfgWe = 1'b0;
  endtask

  task automatic setQ(input int q, input int mi, input int mb, input int xi,
                      input int xb, input int w, input int p);
    cfgWrite(q, 0, mi); cfgWrite(q, 1, mb); cfgWrite(q, 2, xi);
    cfgWrite(q, 3, xb); cfgWrite(q, 4, w); cfgWrite(q, 5, p);
  endtask

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      tick = (i % every == 0);
      cycle();
    end
    tick = 1'b0;
  endtask

  function automatic int cntOf(input logic [NQ*CW-1:0] f, input int q);
    return int'(f[q*CW +: CW]);
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int s3, s6, s7, d6, d7, r2, r5, lf;
    int c0, c1, c2, c3;
    for (int q = 0; q < NQ; q++) begin
      hl[q] = 10;
      mMinInc[q] = 0; mMinBur[q] = 0; mMaxInc[q] = 0; mMaxBur[q] = 0;
      mW[q] = 0; mP[q] = 0; mMinLv[q] = 0; mMaxLv[q] = 0;
      mGc[q] = 0; mYc[q] = 0; mRc[q] = 0;
    end
    mNodeInc = 0; mNodeBur = 0; mNodeLv = 0; gPtr = 0; xPtr = 0; xRun = 0;
    eV = 0; eQ = 0; eG = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(gV == 1'b0, "R1", gV, 0);
    chk(gCntF == '0 && yCntF == '0 && rCntF == '0, "R1", 1, 0);

    // R11: configuration map, incl. clamped priority and ignored node fields
    curReq = "R11";
    setQ(0, 20, 40, 60, 120, 2, 1);
    setQ(1, 20, 40, 60, 120, 1, 3);
    setQ(2, 0, 0, 80, 160, 3, 0);
    setQ(3, 10, 30, 40, 80, 0, 7);
    cfgWrite(NQ, 0, 999);
    cfgWrite(NQ, 2, 200);
    cfgWrite(NQ, 3, 400);
    hl[0] = 30; hl[1] = 25; hl[2] = 40; hl[3] = 20;
    bl = 8'h0F;

    // R2: empty buckets and no tick give no grant
    curReq = "R2";
    for (int i = 0; i < 5; i++) begin
      cycle();
      chk(gV == 1'b0, "R2", gV, 0);
    end

    // R6 and R9: priorities, colours and deductions under periodic credit
    curReq = "R6";
    run(150, 5);
    curReq = "R9";
    run(150, 3);
    chk(cntOf(gCntF, 2) == 0, "R9", cntOf(gCntF, 2), 0);
    chk(cntOf(yCntF, 3) == 0, "R8", cntOf(yCntF, 3), 0);
    chk(cntOf(gCntF, 3) > 0, "R6", cntOf(gCntF, 3), 1);

    // R7: equal-priority green queues rotate
    curReq = "R7";
    bl = '0;
    setQ(4, 100, 400, 100, 400, 1, 2);
    setQ(5, 100, 400, 100, 400, 1, 2);
    bl = 8'h30;
    run(10, 1);
    c0 = cntOf(gCntF, 4); c1 = cntOf(gCntF, 5);
    run(60, 1);
    d6 = cntOf(gCntF, 4) - c0; d7 = cntOf(gCntF, 5) - c1;
    chk(d6 == 30 && d7 == 30, "R7", d6 * 100 + d7, 3030);

    // R8: weighted excess rotation between weights 3 and 1
    curReq = "R8";
    bl = '0;
    setQ(6, 0, 0, 500, 1000, 3, 2);
    setQ(7, 0, 0, 500, 1000, 1, 2);
    bl = 8'hC0;
    run(8, 4);
    s6 = cntOf(yCntF, 6); s7 = cntOf(yCntF, 7);
    run(80, 4);
    d6 = cntOf(yCntF, 6) - s6; d7 = cntOf(yCntF, 7) - s7;
    chk(d7 > 0 && d6 >= 3 * d7 - 3 && d6 <= 3 * d7 + 3, "R8", d6, 3 * d7);

    // R4 and R5: ceiling drained, only protected top queue sends
    curReq = "R4";
    bl = 8'h0F;
    cfgWrite(NQ, 2, 0);
    run(120, 3);
    c0 = cntOf(gCntF, 0) + cntOf(yCntF, 0);
    c1 = cntOf(gCntF, 1) + cntOf(yCntF, 1);
    c2 = cntOf(gCntF, 2) + cntOf(yCntF, 2);
    s3 = cntOf(gCntF, 3);
    curReq = "R5";
    run(200, 3);
    c3 = cntOf(gCntF, 0) + cntOf(yCntF, 0) + cntOf(gCntF, 1) + cntOf(yCntF, 1)
       + cntOf(gCntF, 2) + cntOf(yCntF, 2);
    chk(c3 == c0 + c1 + c2, "R4", c3, c0 + c1 + c2);
    chk(cntOf(gCntF, 3) > s3 + 5, "R5", cntOf(gCntF, 3), s3 + 5);
    chk(cntOf(yCntF, 3) == 0, "R5", cntOf(yCntF, 3), 0);
    cfgWrite(NQ, 2, 4000);

    // R10: red drops only for arrivals to full queues
    curReq = "R10";
    bl = '0;
    r2 = cntOf(rCntF, 2); r5 = cntOf(rCntF, 5);
    full = 8'h24;
    arrQ = 3'd2; arrV = 1'b1;
    run(3, 100);
    full = 8'h20;
    run(2, 100);
    arrV = 1'b0; full = '0;
    run(2, 100);
    chk(cntOf(rCntF, 2) - r2 == 3, "R10", cntOf(rCntF, 2) - r2, 3);
    chk(cntOf(rCntF, 5) == r5, "R10", cntOf(rCntF, 5), r5);

    // R3 and R12: mixed pseudo-random traffic
    curReq = "R12";
    lf = 32'h1ACE;
    for (int i = 0; i < 3000; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
      bl = NQ'(lf);
      tick = (lf[12:10] == 3'd0);
      arrV = lf[20];
      arrQ = QW'(lf >>> 21);
      full = NQ'(lf >>> 24);
      for (int q = 0; q < NQ; q++) hl[q] = 1 + ((lf >>> q) & 8'h3F);
      if (i == 1500) curReq = "R3";
      cycle();
    end
    tick = 1'b0; arrV = 1'b0; bl = '0;
    run(2, 100);
    chk(gV == 1'b0, "R12", gV, 0);
    finishRun();
  end
endmodule